// File: doc/BRIEF.md
# Charging Mode Select and VBUS Power-Cycle Controller

This block picks the operating mode of a charging-capable USB port. The mode comes either from two host select pins or from a 3-bit mode field written by software. It also drives the enable of the port's current-limit switch. When the host changes power state, it moves one or both select pins. After the edge is filtered, the block switches VBUS off for a set number of milliseconds and then switches it back on, so that the attached peripheral restarts.

The off-time is chosen from eight fixed durations by a 3-bit code, and it is counted with an external millisecond tick. A 2-bit override field decides how the enable behaves. It can hold the enable off, hold it on, let every edge power-cycle the port, or power-cycle only when the port enters a mode that is not auto-detect or CDP emulation. The electrical level of the enable pin is selectable. One-cycle strobes mark the start and the end of each power cycle, and a status output is low while a cycle is running.

Top module: `vbus_mode_ctl`

## Requirements
- R1: A select pin change that lasts fewer than DEB_CYCLES clock cycles is ignored: the mode output does not change and no power cycle starts.
- R2: With `use_reg`=0, the mode is taken from the filtered pins. Bit index {0, sel_pin[1], sel_pin[0]} of `mode_onehot` is set, so that 00 gives bit 0 (2A auto-detect), 01 gives bit 1 (pass-through), 10 gives bit 2 (forced dedicated charger) and 11 gives bit 3 (pass-through with CDP emulation).
- R3: With `use_reg`=1, bit `reg_mode` of `mode_onehot` is set, and exactly one bit is ever set. The codes are 0 2A auto-detect, 1 pass-through, 2 forced dedicated, 3 CDP emulation, 4 1A auto-detect, 5 forced 1A divider, 6 forced 2A divider, 7 forced tablet divider.
- R4: With `ovr_ctl`=11, an accepted edge of either select pin drives the enable to its off level, pulses `tog_start` for one cycle and drops `tog_idle`.
- R5: A power cycle ends on the millisecond tick that completes the duration chosen by `dur_code`: 0..7 select 125, 250, 350, 500, 750, 1000, 1500 and 2000 ms. At that point `tog_stop` pulses, `tog_idle` rises and the enable returns to its on level.
- R6: An accepted edge during a running power cycle restarts its duration count from zero and does not pulse `tog_start` again. Two pins changing together start only one cycle.
- R7: `ovr_ctl`=00 holds the enable at its off level and `ovr_ctl`=10 holds it at its on level. In both cases no power cycle starts, and a running cycle is dropped without a `tog_stop` pulse.
- R8: With `ovr_ctl`=01, an edge after which the mode is 2A auto-detect, 1A auto-detect or CDP emulation starts no power cycle. An edge into any other mode starts one.
- R9: With `pol_high`=1 the on level of `vbus_en` is 1. With `pol_high`=0 the on level is 0.
- R10: After reset the enable is at its on level, `tog_idle` is 1, both strobes are 0, and the filtered pins read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pin | input | 2 | Host select pins, asynchronous |
| use_reg | input | 1 | 1: mode from reg_mode, 0: mode from pins |
| reg_mode | input | 3 | Register mode code |
| dur_code | input | 3 | Power-cycle duration code |
| ovr_ctl | input | 2 | Enable override field |
| pol_high | input | 1 | 1: enable is active-high |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| mode_onehot | output | 8 | One-hot mode indication |
| vbus_en | output | 1 | Current-limit switch enable |
| tog_start | output | 1 | Power cycle start strobe |
| tog_stop | output | 1 | Power cycle end strobe |
| tog_idle | output | 1 | High when no power cycle is running |

## Verification
Two pairs of events can land in the same cycle. In the first, both select pins change in one stroke and their filtered edges coincide. The bench makes that change and requires exactly one start strobe and a single off-time of the programmed length. In the second, a new pin edge arrives while a power cycle is still counting, so a restart competes with the ongoing count. The bench flips a pin partway through a cycle, then checks that no second start strobe appears and that the off-time, measured from the first strobe, equals the elapsed gap plus the full duration.

// File: rtl/vbus_ctl_pkg.sv
`timescale 1ns/1ps
package vbus_ctl_pkg;

  typedef enum logic [2:0] {
    MD_AUTO2A  = 3'd0,
    MD_PASS    = 3'd1,
    MD_FORCED  = 3'd2,
    MD_CDPEMU  = 3'd3,
    MD_AUTO1A  = 3'd4,
    MD_DIV1A   = 3'd5,
    MD_DIV2A   = 3'd6,
    MD_DIVTAB  = 3'd7
  } chg_mode_e;

  typedef enum logic [1:0] {
    OV_HOLD_OFF  = 2'd0,
    OV_QUIET_AUT = 2'd1,
    OV_HOLD_ON   = 2'd2,
    OV_FOLLOW    = 2'd3
  } ovr_e;

  localparam int DUR_W = 11;

  // Off-time in milliseconds for each duration code
  function automatic logic [DUR_W-1:0] dur_ms(input logic [2:0] code);
    logic [DUR_W-1:0] v;
    case (code)
      3'd0: v = 11'd125;
      3'd1: v = 11'd250;
      3'd2: v = 11'd350;
      3'd3: v = 11'd500;
      3'd4: v = 11'd750;
      3'd5: v = 11'd1000;
      3'd6: v = 11'd1500;
      default: v = 11'd2000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sel_filter.sv
`timescale 1ns/1ps
module sel_filter #(
  parameter int N_SEL      = 2,
  parameter int DEB_CYCLES = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEL-1:0] raw,
  output logic [N_SEL-1:0] stable,
  output logic [N_SEL-1:0] chg
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  for (genvar g = 0; g < N_SEL; g++) begin : g_bit
    logic          s1_q, s2_q;
    logic          st_q, st_d;
    logic          chg_q, chg_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    always_comb begin
      st_d   = st_q;
      cnt_d  = '0;
      if (s2_q != st_q) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          st_d  = s2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      chg_d  = (st_d != st_q);
      cnt_en = (cnt_d != cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        st_q  <= 1'b0;
        chg_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        s1_q  <= raw[g];
        s2_q  <= s1_q;
        st_q  <= st_d;
        chg_q <= chg_d;
        if (cnt_en) cnt_q <= cnt_d;
      end
    end

    assign stable[g] = st_q;
    assign chg[g]    = chg_q;
  end
endmodule

// File: rtl/mode_select.sv
`timescale 1ns/1ps
module mode_select
  import vbus_ctl_pkg::*;
#(
  parameter int N_MODES = 8
) (
  input  logic [1:0]         pins,
  input  logic               use_reg,
  input  logic [2:0]         reg_mode,
  output chg_mode_e          mode,
  output logic [N_MODES-1:0] onehot
);
  always_comb begin
    if (use_reg) mode = chg_mode_e'(reg_mode);
    else         mode = chg_mode_e'({1'b0, pins});
    onehot = '0;
    onehot[mode] = 1'b1;
  end
endmodule

// File: rtl/vbus_toggle_timer.sv
`timescale 1ns/1ps
module vbus_toggle_timer
  import vbus_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_in,
  input  logic       edge_ok,
  input  ovr_e       ovr,
  input  logic       ms_tick,
  input  logic [2:0] dur_code,
  output logic       busy,
  output logic       start_stb,
  output logic       stop_stb
);
  logic             busy_q, busy_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             start_d, stop_d;
  logic             cycling, cnt_en;
  logic [DUR_W-1:0] cnt_inc;

  always_comb begin
    cycling = (ovr == OV_FOLLOW) || (ovr == OV_QUIET_AUT);
    cnt_inc = cnt_q + 1'b1;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    if (!cycling) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (edge_in && edge_ok) begin
      busy_d  = 1'b1;
      cnt_d   = '0;
      start_d = !busy_q;
    end else if (busy_q && ms_tick) begin
      if (cnt_inc >= dur_ms(dur_code)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        stop_d = 1'b1;
      end else begin
        cnt_d  = cnt_inc;
      end
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      start_stb <= 1'b0;
      stop_stb  <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      start_stb <= start_d;
      stop_stb  <= stop_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/vbus_mode_ctl.sv
`timescale 1ns/1ps
module vbus_mode_ctl
  import vbus_ctl_pkg::*;
#(
  parameter int DEB_CYCLES = 12500,
  parameter int N_MODES    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         sel_pin,
  input  logic               use_reg,
  input  logic [2:0]         reg_mode,
  input  logic [2:0]         dur_code,
  input  logic [1:0]         ovr_ctl,
  input  logic               pol_high,
  input  logic               ms_tick,
  output logic [N_MODES-1:0] mode_onehot,
  output logic               vbus_en,
  output logic               tog_start,
  output logic               tog_stop,
  output logic               tog_idle
);
  logic [1:0] pins_st, pins_chg;
  chg_mode_e  mode;
  ovr_e       ovr;
  logic       busy, edge_ok, en_on;

  assign ovr = ovr_e'(ovr_ctl);

  sel_filter #(.N_SEL(2), .DEB_CYCLES(DEB_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(sel_pin),
    .stable(pins_st), .chg(pins_chg)
  );

  mode_select #(.N_MODES(N_MODES)) u_mode (
    .pins(pins_st), .use_reg(use_reg), .reg_mode(reg_mode),
    .mode(mode), .onehot(mode_onehot)
  );

  // Quiet override skips power cycles on edges into auto-detect or CDP modes
  always_comb begin
    edge_ok = 1'b1;
    if (ovr == OV_QUIET_AUT)
      edge_ok = !((mode == MD_AUTO2A) || (mode == MD_AUTO1A) || (mode == MD_CDPEMU));
  end

  vbus_toggle_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .edge_in(|pins_chg), .edge_ok(edge_ok),
    .ovr(ovr), .ms_tick(ms_tick), .dur_code(dur_code),
    .busy(busy), .start_stb(tog_start), .stop_stb(tog_stop)
  );

  always_comb begin
    case (ovr)
      OV_HOLD_OFF: en_on = 1'b0;
      OV_HOLD_ON:  en_on = 1'b1;
      default:     en_on = !busy;
    endcase
    vbus_en  = pol_high ? en_on : !en_on;
    tog_idle = !busy;
  end
endmodule

// File: rtl/vbus_mode_ctl_chk.sv
`timescale 1ns/1ps
module vbus_mode_ctl_chk #(
  parameter int N_MODES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         ovr_ctl,
  input logic               pol_high,
  input logic [N_MODES-1:0] mode_onehot,
  input logic               vbus_en,
  input logic               tog_start,
  input logic               tog_stop,
  input logic               tog_idle
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tog_start |-> !tog_idle); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tog_stop |-> (tog_idle && $past(!tog_idle))); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tog_start && tog_stop)); // R6
  AST_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ctl == 2'b10) |-> (vbus_en == pol_high)); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ctl == 2'b00) |=> tog_idle); // R7
  AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ctl == 2'b11 && !tog_idle) |-> (vbus_en != pol_high)); // R9
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ctl == 2'b11 && tog_idle) |-> (vbus_en == pol_high)); // R9
endmodule

bind vbus_mode_ctl vbus_mode_ctl_chk #(.N_MODES(N_MODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_ctl(ovr_ctl), .pol_high(pol_high),
  .mode_onehot(mode_onehot), .vbus_en(vbus_en), .tog_start(tog_start),
  .tog_stop(tog_stop), .tog_idle(tog_idle)
);

// File: tb/vbus_mode_ctl_test.sv
`timescale 1ns/1ps
module vbus_mode_ctl_test;
  localparam int DEB  = 8;
  localparam int TDIV = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel_pin;
  logic       use_reg;
  logic [2:0] reg_mode, dur_code;
  logic [1:0] ovr_ctl;
  logic       pol_high;
  logic       ms_tick;
  logic [7:0] mode_onehot;
  logic       vbus_en, tog_start, tog_stop, tog_idle;

  always #2.5 clk = ~clk;

  vbus_mode_ctl #(.DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin), .use_reg(use_reg),
    .reg_mode(reg_mode), .dur_code(dur_code), .ovr_ctl(ovr_ctl),
    .pol_high(pol_high), .ms_tick(ms_tick), .mode_onehot(mode_onehot),
    .vbus_en(vbus_en), .tog_start(tog_start), .tog_stop(tog_stop),
    .tog_idle(tog_idle)
  );

  typedef struct { int lo; int hi; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_err = 0, n_start = 0, n_stop = 0, cyc = 0, st = 0;
  int tdc = 0;
  bit done = 0;
  int dur_tab[8] = '{125, 250, 350, 500, 750, 1000, 1500, 2000};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdc     <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    ms_tick <= (tdc == TDIV - 1);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each stop strobe pops one expected off-time window
  always @(negedge clk) begin
    if (rst_n) begin
      if (tog_start) begin n_start++; st = cyc; end
      if (tog_stop) begin
        int len;
        n_stop++;
        len = cyc - st;
        n_chk++;
        if (q.size() == 0) begin
          n_err++;
          $display("FAIL R5 unexpected stop actual=%0d expected=none", len);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (len < e.lo || len > e.hi) begin
            n_err++;
            $display("FAIL %s off-time actual=%0d expected=%0d..%0d", e.tag, len, e.lo, e.hi);
          end
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [1:0] v);
    @(negedge clk);
    sel_pin = v;
    step(DEB + 8);
  endtask

  task automatic expect_cycle(input int ms, input string tag);
    q.push_back('{lo: (ms - 1) * TDIV, hi: ms * TDIV + 2, tag: tag});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2100 * TDIV && !tog_idle; i++) @(negedge clk);
    step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int s0, s1, c, base;
    rst_n = 1'b0; sel_pin = 2'b00; use_reg = 1'b0; reg_mode = 3'd0;
    dur_code = 3'd0; ovr_ctl = 2'b11; pol_high = 1'b1; ms_tick = 1'b0;
    step(4);
    chk(vbus_en == 1'b1, "R10 vbus_en", int'(vbus_en), 1);
    chk(tog_idle == 1'b1, "R10 tog_idle", int'(tog_idle), 1);
    @(negedge clk) rst_n = 1'b1;
    step(2);
    chk(mode_onehot == 8'h01, "R10 mode", int'(mode_onehot), 1);
    chk(!tog_start && !tog_stop, "R10 strobes", int'({tog_start, tog_stop}), 0);

    // R2 pin decode with cycling held off
    ovr_ctl = 2'b10;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] v;
      v = 2'(i ^ 1);
      set_pins(v);
      chk(mode_onehot == (8'h01 << v), "R2 pin mode", int'(mode_onehot), int'(8'h01 << v));
    end
    chk(n_start == 0, "R7 hold-on no cycle", n_start, 0);
    chk(vbus_en == 1'b1, "R7 hold-on level", int'(vbus_en), 1);

    // R3 register mode
    use_reg = 1'b1;
    for (int m = 0; m < 8; m++) begin
      reg_mode = 3'(m);
      step(2);
      chk(mode_onehot == (8'h01 << m), "R3 reg mode", int'(mode_onehot), int'(8'h01 << m));
    end
    use_reg = 1'b0;

    // R4/R5 every duration code
    ovr_ctl = 2'b11;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] v;
      v = (i % 2 == 0) ? 2'b01 : 2'b00;
      dur_code = 3'(i);
      expect_cycle(dur_tab[i], "R5");
      base = n_start;
      set_pins(v);
      chk(n_start == base + 1, "R4 start strobe", n_start, base + 1);
      chk(vbus_en == 1'b0 && !tog_idle, "R4 off level", int'({vbus_en, tog_idle}), 0);
      wait_idle();
      chk(vbus_en == 1'b1, "R5 on after cycle", int'(vbus_en), 1);
    end

    // R1 short glitch ignored (pins now 00)
    base = n_start;
    @(negedge clk) sel_pin = 2'b01;
    step(DEB - 4);
    sel_pin = 2'b00;
    step(3 * DEB);
    chk(n_start == base, "R1 glitch no cycle", n_start, base);
    chk(mode_onehot == 8'h01, "R1 glitch mode", int'(mode_onehot), 1);

    // R6 restart during a running cycle
    dur_code = 3'd0;
    base = n_start;
    @(negedge clk) sel_pin = 2'b01;
    for (int i = 0; i < 4 * DEB && n_start == base; i++) @(negedge clk);
    s0 = cyc;
    step(60 * TDIV);
    c = cyc;
    q.push_back('{lo: (c - s0) + 124 * TDIV, hi: (c - s0) + 125 * TDIV + DEB + 8, tag: "R6 restart"});
    set_pins(2'b00);
    wait_idle();
    chk(n_start == base + 1, "R6 single start", n_start, base + 1);

    // R6 both pins at once -> one cycle
    base = n_start;
    expect_cycle(125, "R6 dual edge");
    set_pins(2'b11);
    wait_idle();
    chk(n_start == base + 1, "R6 dual edge starts", n_start, base + 1);
    set_pins(2'b00);
    expect_cycle(125, "R5");
    wait_idle();

    // R7 hold-off
    ovr_ctl = 2'b00;
    step(2);
    chk(vbus_en == 1'b0, "R7 hold-off level", int'(vbus_en), 0);
    base = n_start;
    set_pins(2'b01);
    chk(n_start == base, "R7 hold-off no cycle", n_start, base);

    // R7 cancel a running cycle without stop strobe
    ovr_ctl = 2'b11;
    dur_code = 3'd7;
    set_pins(2'b00);
    step(50);
    chk(!tog_idle, "R7 cycle running", int'(tog_idle), 0);
    s1 = n_stop;
    ovr_ctl = 2'b10;
    step(2);
    chk(tog_idle && vbus_en, "R7 cancel", int'({tog_idle, vbus_en}), 3);
    step(100);
    chk(n_stop == s1, "R7 cancel no stop", n_stop, s1);

    // R8 quiet override
    ovr_ctl = 2'b01;
    dur_code = 3'd0;
    base = n_start;
    expect_cycle(125, "R8 into pass");
    set_pins(2'b01);
    chk(n_start == base + 1, "R8 into pass starts", n_start, base + 1);
    wait_idle();
    set_pins(2'b11);
    chk(n_start == base + 1, "R8 into cdp quiet", n_start, base + 1);
    expect_cycle(125, "R8 into forced");
    set_pins(2'b10);
    chk(n_start == base + 2, "R8 into forced starts", n_start, base + 2);
    wait_idle();
    set_pins(2'b00);
    chk(n_start == base + 2, "R8 into auto quiet", n_start, base + 2);

    // R9 active-low enable
    ovr_ctl = 2'b11;
    pol_high = 1'b0;
    step(2);
    chk(vbus_en == 1'b0, "R9 low-active on", int'(vbus_en), 0);
    expect_cycle(125, "R9");
    set_pins(2'b01);
    chk(vbus_en == 1'b1, "R9 low-active off", int'(vbus_en), 1);
    wait_idle();
    chk(vbus_en == 1'b0, "R9 low-active restore", int'(vbus_en), 0);

    step(4);
    chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule